// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one direct-memory-access channel. Software programs a source address, a destination address, an item count and a control word through a small write-only register port. The channel then runs as a bus master and moves the items one at a time, each as a single read beat followed by a single write beat. Items can be 8, 16 or 32 bits wide. Transfers can go from a peripheral to memory, from memory to a peripheral, or from memory to memory. Each peripheral-side item waits for the peripheral's request line. Memory-to-memory items run back to back, limited only by how fast the bus answers.

The channel has two modes. In one-shot mode it stops after the programmed count and drops its own enable. In ring mode it reloads both pointers and the count at the end of the buffer and keeps going until software turns it off. A half-way flag and an end-of-buffer flag let the CPU work on one half of a ring buffer while the engine fills the other half. Three flags are sticky: half, done and error. Each can be enabled onto one interrupt line.

Top module: `dma_xfer_channel`

## Requirements
- R1: The direction field is CTRL[4:3]: 0 means peripheral to memory, 1 means memory to peripheral, 2 means memory to memory. The peripheral-side address stays fixed. The memory-side address advances by the item size after each item. In memory-to-memory mode both addresses advance.
- R2: The width field is CTRL[2:1]: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit. `bus_size` carries this code. Write data is the read data right-justified, with every bit above the item width forced to zero.
- R3: In the two peripheral directions, no bus beat starts while `periph_req` is low. One item is moved per request. `req_ack` pulses high for one cycle after that item's write is accepted.
- R4: In memory-to-memory mode, items proceed without `periph_req`. The number of write beats equals the programmed count.
- R5: In one-shot mode (CTRL[5]=0), exactly COUNT items are written and nothing past them. `chan_on` then drops. Setting CTRL[0] again starts a new transfer from the programmed addresses.
- R6: In ring mode (CTRL[5]=1), after the last item both pointers reload to the programmed addresses and transfers continue. Clearing CTRL[0] stops the channel once the item in flight completes.
- R7: The half flag (status bit 0) is set when item COUNT/2 (integer division) completes, and never when COUNT/2 is zero. The done flag (status bit 1) is set when the last item completes.
- R8: The error flag (status bit 2) is set and the channel disabled without any bus beat in these cases: COUNT is zero, the width code is 3, the direction code is 3, or either address is not a multiple of the item size.
- R9: A bus error response on either beat sets the error flag and disables the channel. A failed read produces no write.
- R10: Writing 1 to a bit at register 4 clears that flag; writing 0 leaves it. `irq` is high when any flag whose enable (CTRL[6] half, CTRL[7] done, CTRL[8] error) is set is itself set.
- R11: Once `bus_req` is raised, it stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle in which `bus_ready` is high.
- R12: After reset `bus_req`, `req_ack`, `status`, `irq` and `chan_on` are all low.

The register selects are: 0 CTRL, 1 source address, 2 destination address, 3 COUNT, 4 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| periph_req | input | 1 | Peripheral ready for one item |
| req_ack | output | 1 | One-cycle pulse after a paced item completes |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_addr | output | AW | Beat byte address |
| bus_size | output | 2 | Item width code |
| bus_wdata | output | DW | Write data, right-justified |
| bus_rdata | input | DW | Read data, right-justified |
| bus_ready | input | 1 | Beat accepted this cycle |
| bus_err | input | 1 | Error response, valid with bus_ready |
| status | output | 3 | Sticky flags: error, done, half |
| irq | output | 1 | OR of the enabled flags |
| chan_on | output | 1 | Channel enable state |

## Verification
The bench sweeps every width against counts 1 to 5. A design that stepped the pointer by the wrong stride, or wrote one item too many, would corrupt the guard byte or scramble the copied image. It holds the peripheral request low for a long stretch and then releases it one item at a time, so an engine that ignored pacing or moved two items per request shows a wrong read count. Ring mode is checked through the logged write addresses, which must wrap to the buffer start. Every illegal setup and both bus-error positions are also tried: an engine that masked low address bits or wrote after a failed read would either move data or leave the enable set.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned NFLAG  = 3;
  localparam int unsigned FL_HALF = 0;
  localparam int unsigned FL_DONE = 1;
  localparam int unsigned FL_ERR  = 2;

  localparam logic [SEL_W-1:0] RA_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] RA_SRC  = 3'd1;
  localparam logic [SEL_W-1:0] RA_DST  = 3'd2;
  localparam logic [SEL_W-1:0] RA_CNT  = 3'd3;
  localparam logic [SEL_W-1:0] RA_FLAG = 3'd4;

  typedef enum logic [1:0] {DIR_P2M = 2'd0, DIR_M2P = 2'd1, DIR_M2M = 2'd2, DIR_BAD = 2'd3} dir_e;
  typedef enum logic [1:0] {WID_B = 2'd0, WID_H = 2'd1, WID_W = 2'd2, WID_BAD = 2'd3} wid_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RD, ST_WR} st_e;

  function automatic logic [2:0] wid_bytes(wid_e w);
    case (w)
      WID_B:   return 3'd1;
      WID_H:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             clr_en,
  input  logic [NFLAG-1:0] set_flags,
  output logic             en_q,
  output wid_e             wid_q,
  output dir_e             dir_q,
  output logic             circ_q,
  output logic [AW-1:0]    src_q,
  output logic [AW-1:0]    dst_q,
  output logic [CW-1:0]    cnt_q,
  output logic [NFLAG-1:0] flag_q,
  output logic             irq_q
);
  logic [NFLAG-1:0] ie_q;
  logic             wr_ctrl, wr_flag;

  assign wr_ctrl = cfg_we && (cfg_sel == RA_CTRL);
  assign wr_flag = cfg_we && (cfg_sel == RA_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      wid_q  <= WID_B;
      dir_q  <= DIR_P2M;
      circ_q <= 1'b0;
      ie_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        wid_q  <= wid_e'(cfg_wdata[2:1]);
        dir_q  <= dir_e'(cfg_wdata[4:3]);
        circ_q <= cfg_wdata[5];
        ie_q   <= cfg_wdata[6 +: NFLAG];
      end
      if (clr_en)       en_q <= 1'b0;
      else if (wr_ctrl) en_q <= cfg_wdata[0];
      if (cfg_we && cfg_sel == RA_SRC) src_q <= cfg_wdata[AW-1:0];
      if (cfg_we && cfg_sel == RA_DST) dst_q <= cfg_wdata[AW-1:0];
      if (cfg_we && cfg_sel == RA_CNT) cnt_q <= cfg_wdata[CW-1:0];
      irq_q <= |(flag_q & ie_q);
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= set_flags[i] | (flag_q[i] & ~(wr_flag & cfg_wdata[i]));
    end

    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
      (wr_flag && cfg_wdata[i] && !set_flags[i]) |=> !flag_q[i]);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !(wr_flag && cfg_wdata[i])) |=> flag_q[i]);
  end
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_start,
  input  logic [AW-1:0] dst_start,
  input  logic          inc_src,
  input  logic          inc_dst,
  input  logic [2:0]    stride,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst
);
  localparam int unsigned NSIDE = 2;
  logic [AW-1:0] seed [NSIDE];
  logic          adv  [NSIDE];

  assign seed[0] = src_start;
  assign seed[1] = dst_start;
  assign adv[0]  = inc_src;
  assign adv[1]  = inc_dst;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic [AW-1:0] ptr;
    always_ff @(posedge clk) begin
      if (rst)                  ptr <= '0;
      else if (load)            ptr <= seed[s];
      else if (step && adv[s])  ptr <= ptr + AW'(stride);
    end
  end

  assign cur_src = g_side[0].ptr;
  assign cur_dst = g_side[1].ptr;
endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
  import dmach_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  wid_e             cfg_wid,
  input  dir_e             cfg_dir,
  input  logic             cfg_circ,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [CW-1:0]    cfg_cnt,
  input  logic [AW-1:0]    cur_src,
  input  logic [AW-1:0]    cur_dst,
  input  logic             periph_req,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ready,
  input  logic             bus_err,
  output logic             addr_load,
  output logic             addr_step,
  output logic             inc_src,
  output logic             inc_dst,
  output logic [2:0]       stride,
  output logic [NFLAG-1:0] set_flags,
  output logic             clr_en,
  output logic             req_ack,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [1:0]       bus_size,
  output logic [DW-1:0]    bus_wdata
);
  st_e           st;
  wid_e          wid_q;
  dir_e          dir_q;
  logic          circ_q;
  logic [CW-1:0] n_q, idx, idx_nx, half_n;
  logic [AW-1:0] amask_cfg, amask_q;
  logic [DW-1:0] dmask;
  logic          bad_cfg, start_ok, start_bad, wr_ok, bus_fail, last, half_hit, paced;

  always_comb begin
    amask_cfg = AW'(wid_bytes(cfg_wid) - 3'd1);
    amask_q   = AW'(wid_bytes(wid_q) - 3'd1);
    bad_cfg   = (cfg_cnt == '0) || (cfg_wid == WID_BAD) || (cfg_dir == DIR_BAD) ||
                (|(cfg_src & amask_cfg)) || (|(cfg_dst & amask_cfg));
    start_ok  = (st == ST_IDLE) && cfg_en && !bad_cfg;
    start_bad = (st == ST_IDLE) && cfg_en && bad_cfg;
    wr_ok     = (st == ST_WR) && bus_ready && !bus_err;
    bus_fail  = ((st == ST_RD) || (st == ST_WR)) && bus_ready && bus_err;
    idx_nx    = idx + CW'(1);
    half_n    = n_q >> 1;
    last      = (idx_nx == n_q);
    half_hit  = (half_n != '0) && (idx_nx == half_n);
    paced     = (dir_q != DIR_M2M);
    case (wid_q)
      WID_B:   dmask = DW'(8'hFF);
      WID_H:   dmask = DW'(16'hFFFF);
      default: dmask = '1;
    endcase
    set_flags          = '0;
    set_flags[FL_HALF] = wr_ok && half_hit;
    set_flags[FL_DONE] = wr_ok && last;
    set_flags[FL_ERR]  = start_bad || bus_fail;
    clr_en    = start_bad || bus_fail || (wr_ok && last && !circ_q);
    addr_load = start_ok || (wr_ok && last && circ_q);
    addr_step = wr_ok && !last;
    inc_src   = (dir_q != DIR_P2M);
    inc_dst   = (dir_q != DIR_M2P);
    stride    = wid_bytes(wid_q);
  end

  assign bus_size = wid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wid_q     <= WID_B;
      dir_q     <= DIR_P2M;
      circ_q    <= 1'b0;
      n_q       <= '0;
      idx       <= '0;
      req_ack   <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      req_ack <= 1'b0;
      case (st)
        ST_IDLE: if (start_ok) begin
          wid_q  <= cfg_wid;
          dir_q  <= cfg_dir;
          circ_q <= cfg_circ;
          n_q    <= cfg_cnt;
          idx    <= '0;
          st     <= ST_ARM;
        end
        ST_ARM: begin
          if (!cfg_en) st <= ST_IDLE;
          else if (!paced || periph_req) begin
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= cur_src;
            st       <= ST_RD;
          end
        end
        ST_RD: if (bus_ready) begin
          if (bus_err) begin
            bus_req <= 1'b0;
            st      <= ST_IDLE;
          end else begin
            bus_we    <= 1'b1;
            bus_addr  <= cur_dst;
            bus_wdata <= bus_rdata & dmask;
            st        <= ST_WR;
          end
        end
        ST_WR: if (bus_ready) begin
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
          if (bus_err) st <= ST_IDLE;
          else begin
            req_ack <= paced;
            if (!last) begin
              idx <= idx_nx;
              st  <= ST_ARM;
            end else if (circ_q) begin
              idx <= '0;
              st  <= ST_ARM;
            end else begin
              st  <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  assert_pace_R3: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_ARM) && paced && !periph_req) |=> !bus_req);
  assert_align_R8: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> ((bus_addr & amask_q) == '0));
  assert_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (set_flags[FL_DONE] && !circ_q) |=> ((st == ST_IDLE) && !bus_req));
  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    bus_fail |=> ((st == ST_IDLE) && !bus_req));
endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
  import dmach_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             periph_req,
  output logic             req_ack,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [1:0]       bus_size,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ready,
  input  logic             bus_err,
  output logic [NFLAG-1:0] status,
  output logic             irq,
  output logic             chan_on
);
  logic             en_q, circ_q, clr_en, addr_load, addr_step, inc_src, inc_dst;
  wid_e             wid_q;
  dir_e             dir_q;
  logic [AW-1:0]    src_q, dst_q, cur_src, cur_dst;
  logic [CW-1:0]    cnt_q;
  logic [NFLAG-1:0] set_flags;
  logic [2:0]       stride;

  dmach_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .clr_en(clr_en), .set_flags(set_flags), .en_q(en_q), .wid_q(wid_q), .dir_q(dir_q),
    .circ_q(circ_q), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .flag_q(status), .irq_q(irq)
  );

  dmach_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .step(addr_step), .src_start(src_q),
    .dst_start(dst_q), .inc_src(inc_src), .inc_dst(inc_dst), .stride(stride),
    .cur_src(cur_src), .cur_dst(cur_dst)
  );

  dmach_fsm #(.AW(AW), .CW(CW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .cfg_en(en_q), .cfg_wid(wid_q), .cfg_dir(dir_q), .cfg_circ(circ_q),
    .cfg_src(src_q), .cfg_dst(dst_q), .cfg_cnt(cnt_q), .cur_src(cur_src), .cur_dst(cur_dst),
    .periph_req(periph_req), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .addr_load(addr_load), .addr_step(addr_step), .inc_src(inc_src), .inc_dst(inc_dst),
    .stride(stride), .set_flags(set_flags), .clr_en(clr_en), .req_ack(req_ack),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata)
  );

  assign chan_on = en_q;
endmodule

// File: tb/tb_dma_xfer_channel.sv
module tb_dma_xfer_channel;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, cfg_we, periph_req, bus_ready, bus_err;
  logic [2:0]    cfg_sel;
  logic [31:0]   cfg_wdata;
  logic [DW-1:0] bus_rdata;
  logic          req_ack, bus_req, bus_we, irq, chan_on;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic [2:0]    status;

  dma_xfer_channel #(.AW(AW), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .periph_req(periph_req), .req_ack(req_ack), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .status(status), .irq(irq), .chan_on(chan_on)
  );

  int errors = 0, checks = 0;
  logic [7:0]  mem [256];
  logic [7:0]  wlog [256];
  logic [31:0] plog [16];
  logic [7:0]  pseq, ra;
  int pn = 0, nrd = 0, nwr = 0, reqcyc = 0, lat = 0, wcnt = 0, nb = 0, hviol = 0;
  logic          pend = 1'b0, pwe = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pdata = '0;

  // bus slave model: byte memory, read port at 0x80, write port at 0x84, error at >= 0xF0
  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 1'b0; bus_err = 1'b0; wcnt = 0; pend = 1'b0;
    end else begin
      if (pend && !bus_ready)
        if (!(bus_req && bus_addr == paddr && bus_we == pwe && bus_wdata == pdata)) hviol++;
      pend = bus_req; paddr = bus_addr; pwe = bus_we; pdata = bus_wdata;
      if (bus_req) reqcyc++;
      if (bus_ready) begin
        bus_ready = 1'b0; bus_err = 1'b0; wcnt = 0;
      end else if (bus_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          ra = bus_addr[7:0];
          nb = 1 << bus_size;
          bus_err = (bus_addr >= 32'hF0);
          if (!bus_err) begin
            if (bus_we) begin
              if (ra == 8'h84) begin plog[pn % 16] = bus_wdata; pn++; end
              else for (int j = 0; j < nb; j++) mem[8'(ra + j)] = bus_wdata[8*j +: 8];
              wlog[nwr % 256] = ra; nwr++;
            end else begin
              if (ra == 8'h80) begin
                bus_rdata = {pseq + 8'd3, pseq + 8'd2, pseq + 8'd1, pseq}; pseq++;
              end else begin
                bus_rdata = 32'hA5A5A5A5;
                for (int j = 0; j < nb; j++) bus_rdata[8*j +: 8] = mem[8'(ra + j)];
              end
              nrd++;
            end
          end
          bus_ready = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input int en, input int w, input int dir, input int circ, input int ie);
    return 32'(en | (w << 1) | (dir << 3) | (circ << 5) | (ie << 6));
  endfunction

  task automatic wait_off(output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (!chan_on) begin ok = 1'b1; break; end
    end
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int n);
    wr(3'd1, s); wr(3'd2, d); wr(3'd3, 32'(n));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  int es_src [5] = '{0, 1, 0, 0, 0};
  int es_dst [5] = '{'h40, 'h40, 'h42, 'h40, 'h40};
  int es_cnt [5] = '{0, 2, 2, 2, 2};
  int es_w   [5] = '{0, 1, 2, 3, 0};
  int es_dir [5] = '{2, 2, 2, 2, 3};

  initial begin
    bit ok;
    int bad, r0, n0, n1;
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; periph_req = 1'b0;
    bus_rdata = '0; pseq = 8'h10;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!bus_req && !req_ack, "R12", "bus idle after reset", {bus_req, req_ack}, 0);
    chk(status == 3'b000 && !irq, "R12", "flags/irq after reset", {status, irq}, 0);
    chk(!chan_on, "R12", "chan_on after reset", chan_on, 0);

    // memory-to-memory sweep over widths and counts
    for (int w = 0; w < 3; w++) begin
      for (int n = 1; n <= 5; n++) begin
        lat = (w + n) % 3;
        for (int i = 'h40; i < 'h80; i++) mem[i] = 8'hEE;
        n0 = nwr;
        setup(0, 'h40, n);
        wr(3'd0, ctrl(1, w, 2, 0, 0));
        wait_off(ok);
        chk(ok, "R5", "one-shot run ends", ok, 1);
        repeat (3) @(negedge clk);
        bad = 0;
        for (int k = 0; k < n * (1 << w); k++) if (mem['h40 + k] != mem[k]) bad++;
        chk(bad == 0, "R1", "m2m copy image", bad, 0);
        chk(mem['h40 + n * (1 << w)] == 8'hEE, "R5", "byte past end untouched", mem['h40 + n * (1 << w)], 8'hEE);
        chk(nwr - n0 == n, "R4", "m2m write beats", nwr - n0, n);
        chk(status == {1'b0, 1'b1, 1'((n / 2) != 0)}, "R7", "flags after one-shot", status, {1'b0, 1'b1, 1'((n / 2) != 0)});
        wr(3'd4, 7);
      end
    end

    // R5 restart by setting enable again
    setup(0, 'h40, 3);
    wr(3'd0, ctrl(1, 0, 2, 0, 0));
    wait_off(ok);
    n0 = nwr;
    wr(3'd0, ctrl(1, 0, 2, 0, 0));
    wait_off(ok);
    chk(ok && nwr - n0 == 3, "R5", "re-enable runs again", nwr - n0, 3);
    wr(3'd4, 7);

    // R3 paced peripheral-to-memory, 16-bit
    lat = 1; pseq = 8'h10;
    for (int i = 'h40; i < 'h80; i++) mem[i] = 8'hEE;
    setup('h80, 'h40, 3);
    r0 = reqcyc; n0 = nrd;
    wr(3'd0, ctrl(1, 1, 0, 0, 0));
    repeat (40) @(negedge clk);
    chk(reqcyc == r0, "R3", "no beat without periph_req", reqcyc - r0, 0);
    chk(chan_on, "R3", "channel waits enabled", chan_on, 1);
    for (int k = 0; k < 3; k++) begin
      periph_req = 1'b1;
      for (int t = 0; t < 200; t++) begin
        @(negedge clk);
        if (req_ack) break;
      end
      periph_req = 1'b0;
      repeat (6) @(negedge clk);
      chk(nrd - n0 == k + 1, "R3", "one item per request", nrd - n0, k + 1);
    end
    wait_off(ok);
    repeat (3) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 3; k++)
      for (int j = 0; j < 2; j++) if (mem['h40 + 2*k + j] != 8'(8'h10 + k + j)) bad++;
    chk(bad == 0, "R1", "p2m fixed source, stepping dest", bad, 0);
    chk(status == 3'b011, "R7", "p2m flags count 3", status, 3'b011);
    wr(3'd4, 7);

    // memory-to-peripheral, 16-bit, request held high
    lat = 2; pn = 0;
    setup('h10, 'h84, 4);
    periph_req = 1'b1;
    wr(3'd0, ctrl(1, 1, 1, 0, 0));
    wait_off(ok);
    periph_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(pn == 4, "R1", "m2p writes to fixed port", pn, 4);
    bad = 0;
    for (int k = 0; k < 4; k++)
      if (plog[k] != {16'h0, mem['h10 + 2*k + 1], mem['h10 + 2*k]}) bad++;
    chk(bad == 0, "R2", "m2p data right-justified and masked", bad, 0);
    chk(status == 3'b011, "R7", "m2p flags count 4", status, 3'b011);
    wr(3'd4, 7);

    // R6 ring mode
    lat = 0;
    n0 = nwr;
    setup('h20, 'h40, 4);
    wr(3'd0, ctrl(1, 0, 2, 1, 3));
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (nwr - n0 >= 10) break;
    end
    chk(chan_on, "R6", "ring stays enabled", chan_on, 1);
    bad = 0;
    for (int k = 0; k < 10; k++) if (wlog[(n0 + k) % 256] != 8'('h40 + (k % 4))) bad++;
    chk(bad == 0, "R6", "ring write addresses wrap", bad, 0);
    chk(status[1:0] == 2'b11, "R7", "ring half and done", status[1:0], 2'b11);
    chk(irq, "R10", "irq from enabled half/done", irq, 1);
    wr(3'd0, ctrl(0, 0, 2, 1, 0));
    repeat (10) @(negedge clk);
    n1 = nwr;
    repeat (20) @(negedge clk);
    chk(nwr == n1 && !bus_req && !chan_on, "R6", "disable stops ring", nwr - n1, 0);
    wr(3'd4, 7);
    repeat (3) @(negedge clk);
    chk(status == 3'b000 && !irq, "R10", "flags cleared", status, 0);

    // R8 illegal setups
    for (int e = 0; e < 5; e++) begin
      setup(32'(es_src[e]), 32'(es_dst[e]), es_cnt[e]);
      r0 = reqcyc;
      wr(3'd0, ctrl(1, es_w[e], es_dir[e], 0, 4));
      repeat (5) @(negedge clk);
      chk(status == 3'b100, "R8", "error flag on bad setup", status, 3'b100);
      chk(!chan_on, "R8", "channel disabled on bad setup", chan_on, 0);
      chk(reqcyc == r0, "R8", "no bus beat on bad setup", reqcyc - r0, 0);
      chk(irq, "R10", "irq from error flag", irq, 1);
      wr(3'd4, 4);
      repeat (3) @(negedge clk);
      chk(status == 3'b000 && !irq, "R10", "error flag cleared", {status, irq}, 0);
    end

    // R9 bus errors on read and on write
    lat = 1;
    n0 = nwr;
    setup('hF0, 'h40, 2);
    wr(3'd0, ctrl(1, 0, 2, 0, 0));
    wait_off(ok);
    repeat (3) @(negedge clk);
    chk(ok && status == 3'b100, "R9", "read error sets flag", status, 3'b100);
    chk(nwr == n0, "R9", "no write after failed read", nwr - n0, 0);
    wr(3'd4, 7);
    setup('h00, 'hF4, 2);
    wr(3'd0, ctrl(1, 0, 2, 0, 0));
    wait_off(ok);
    repeat (3) @(negedge clk);
    chk(ok && status == 3'b100, "R9", "write error sets flag and stops", status, 3'b100);
    wr(3'd4, 7);

    // R10 selective clear and per-flag enable
    setup(0, 'h40, 2);
    wr(3'd0, ctrl(1, 0, 2, 0, 0));
    wait_off(ok);
    repeat (3) @(negedge clk);
    wr(3'd4, 1);
    repeat (2) @(negedge clk);
    chk(status == 3'b010, "R10", "clear half only", status, 3'b010);
    chk(!irq, "R10", "no irq with enables off", irq, 0);
    wr(3'd0, ctrl(0, 0, 2, 0, 2));
    repeat (3) @(negedge clk);
    chk(irq, "R10", "irq from done enable", irq, 1);
    wr(3'd0, ctrl(0, 0, 2, 0, 1));
    repeat (3) @(negedge clk);
    chk(!irq, "R10", "half enable with half clear", irq, 0);

    chk(hviol == 0, "R11", "request held stable until ready", hviol, 0);
    finish_run();
  end
endmodule